// File: doc/BRIEF.md
# Three-wire serial EEPROM master

This block drives a three-wire serial EEPROM that stores 16-bit words. It owns the chip-select, serial-clock and serial-data-out pins and samples the device's data line. A host hands it one request at a time: a 2-bit command code, an 8-bit word address and 16 bits of write data. The block turns that request into a serial frame, clocks it out and returns read data with a one-cycle completion pulse. A busy flag covers the whole access.

Right after reset the block probes the device on its own to learn whether it decodes 6 or 8 address bits. That result sets the frame length of every later command. A write frame is followed by a poll of the device's ready indication, with a limit on how long to wait. Bit timing comes from a run-time divider input, so a single build can serve slow and fast parts.

Top module: `mw_eeprom_master`

## Requirements
- R1: When reset is released the block is busy and issues a probe with chip select high: bits 1,1,0 and then eight 1 bits, which is 11 clock pulses. `addr8_o` becomes 1 if the data line sampled after the sixth address bit's clock pulse is 1, and becomes 0 otherwise.
- R2: `di_o` changes only while `sk_o` is low and stays stable while `sk_o` is high. The data line is sampled at the end of each high phase.
- R3: Command code 0 (read) sends 1,1,0, then the address MSB first, then 16 further clock pulses. That is 3+W+16 pulses, where W is 8 or 6 (W=6 uses `addr_i[5:0]`). `rdata_o` holds the last 16 samples, MSB first, from the completion pulse onward.
- R4: Command code 1 (write enable) sends 1,0,0,1,1 followed by W-2 zeros. Command code 2 (write disable) sends 1,0,0 followed by W zeros. Both are 3+W pulses. A write that is not preceded by an enable leaves the stored word unchanged.
- R5: Command code 3 (write) sends 1,0,1, the address and the 16 data bits MSB first. Chip select then drops for one half period and rises again, and the data line is polled once per half period until it reads 1. Chip select rises twice per write.
- R6: Every access ends with chip select low for at least one half period. `done_o` is a one-cycle pulse that marks the end of `busy_o`. During reset the pins are low, `done_o` and `err_o` are 0, and `busy_o` is 1.
- R7: Each level of `sk_o` lasts `half_div_i`+1 clock cycles.
- R8: A request that arrives while `busy_o` is high is ignored. It starts no access and changes no stored word.
- R9: If the poll sees POLL_MAX samples at 0, it stops. `err_o` is 1 when `done_o` pulses, stays 1 until the next request is accepted, and is cleared by that acceptance.
- R10: The detected address width is held until the next reset and sets the frame length of every command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, taken only when idle |
| cmd_i | input | 2 | 0 read, 1 write enable, 2 write disable, 3 write |
| addr_i | input | 8 | Word address |
| wdata_i | input | 16 | Write data |
| half_div_i | input | DIV_W | Half period minus one, in clock cycles |
| busy_o | output | 1 | Access or start-up probe in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last write timed out while polling |
| rdata_o | output | 16 | Last read word |
| addr8_o | output | 1 | 1 when the device uses 8 address bits |
| cs_o | output | 1 | Chip select |
| sk_o | output | 1 | Serial clock |
| di_o | output | 1 | Serial data to the device |
| do_i | input | 1 | Serial data from the device |

## Verification
On every cycle the assertions check four things. Data-out does not move while the serial clock is high, and no clock level is shorter than the programmed half period. Busy only falls after a half period with chip select low, and both the completion pulse and the rise of the error flag are single, coincident events. They also confirm that the width flag never moves once the start-up probe has finished. A behavioural device model in the bench is the only way to show the rest: that frames carry the right opcodes and lengths for both widths, that read data lands in order, that writes are gated by enable and disable, that the poll either ends on the ready level or times out, and that a request made while busy leaves no trace.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned HDR_W      = 3;
  localparam int unsigned ADDR_W_MAX = 8;
  localparam int unsigned ADDR_W_MIN = 6;
  localparam int unsigned FRAME_W    = HDR_W + ADDR_W_MAX + DATA_W;
  localparam int unsigned IDX_W      = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    CMD_READ  = 2'd0,
    CMD_WEN   = 2'd1,
    CMD_WDIS  = 2'd2,
    CMD_WRITE = 2'd3
  } mw_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_BOOT, S_LO, S_HI, S_GAP, S_POLL, S_FIN
  } mw_state_e;
endpackage

// File: rtl/mw_tick_gen.sv
module mw_tick_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (restart_i || tick_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  // a nonzero divider never yields back-to-back ticks
  assert_tick_spacing_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0) |=> (div_i == '0 || !tick_o));
endmodule

// File: rtl/mw_frame_build.sv
module mw_frame_build
  import mw_pkg::*;
(
  input  mw_cmd_e                 cmd_i,
  input  logic [ADDR_W_MAX-1:0]   addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic                    wide_i,
  output logic [FRAME_W-1:0]      frame_o,
  output logic [IDX_W-1:0]        nbits_o
);
  logic [HDR_W-1:0]      hdr;
  logic [ADDR_W_MAX-1:0] fld;
  logic [DATA_W-1:0]     dat;
  logic                  has_data;
  logic [IDX_W-1:0]      aw;

  always_comb begin
    hdr      = '0;
    fld      = '0;
    dat      = '0;
    has_data = 1'b0;
    unique case (cmd_i)
      CMD_READ:  begin hdr = 3'b110; fld = addr_i; has_data = 1'b1; end
      CMD_WRITE: begin hdr = 3'b101; fld = addr_i; dat = wdata_i; has_data = 1'b1; end
      // enable pattern: two ones right after the 00 opcode, left-aligned in the field
      CMD_WEN:   begin hdr = 3'b100; fld = wide_i ? 8'hC0 : 8'h30; end
      CMD_WDIS:  begin hdr = 3'b100; end
      default:   ;
    endcase
  end

  assign aw      = wide_i ? IDX_W'(ADDR_W_MAX) : IDX_W'(ADDR_W_MIN);
  assign nbits_o = IDX_W'(HDR_W) + aw + (has_data ? IDX_W'(DATA_W) : '0);
  assign frame_o = wide_i ? {hdr, fld, dat}
                          : {hdr, fld[ADDR_W_MIN-1:0], dat, {(ADDR_W_MAX-ADDR_W_MIN){1'b0}}};
endmodule

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master
  import mw_pkg::*;
#(
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned POLL_MAX = 10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        cmd_i,
  input  logic [7:0]        addr_i,
  input  logic [15:0]       wdata_i,
  input  logic [DIV_W-1:0]  half_div_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [15:0]       rdata_o,
  output logic              addr8_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  input  logic              do_i
);
  localparam int unsigned      POLL_W    = (POLL_MAX > 2) ? $clog2(POLL_MAX) : 1;
  localparam logic [IDX_W-1:0] DET_BITS  = IDX_W'(HDR_W + ADDR_W_MAX);
  localparam logic [IDX_W-1:0] DET_IDX   = IDX_W'(HDR_W + ADDR_W_MIN - 1);
  localparam logic [FRAME_W-1:0] DET_FRAME = {3'b110, {ADDR_W_MAX{1'b1}}, {DATA_W{1'b0}}};

  mw_state_e          state_q;
  logic [FRAME_W-1:0] tx_q, frame;
  logic [IDX_W-1:0]   nbits_q, idx_q, nbits;
  logic [DATA_W-1:0]  rx_q, rdata_q;
  logic [POLL_W-1:0]  poll_q;
  logic rd_q, wr_q, det_q, wide_q, err_q, tout_q, done_q;
  logic tick, accept, restart;

  assign accept  = (state_q == S_IDLE) && req_i;
  assign restart = accept || (state_q == S_BOOT);

  mw_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart), .div_i(half_div_i), .tick_o(tick)
  );

  mw_frame_build u_frame (
    .cmd_i(mw_cmd_e'(cmd_i)), .addr_i(addr_i), .wdata_i(wdata_i), .wide_i(wide_q),
    .frame_o(frame), .nbits_o(nbits)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_BOOT;
      tx_q <= '0; nbits_q <= '0; idx_q <= '0; rx_q <= '0; rdata_q <= '0; poll_q <= '0;
      rd_q <= 1'b0; wr_q <= 1'b0; det_q <= 1'b0; wide_q <= 1'b0;
      err_q <= 1'b0; tout_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_BOOT: begin
          tx_q <= DET_FRAME; nbits_q <= DET_BITS; idx_q <= '0;
          det_q <= 1'b1; rd_q <= 1'b0; wr_q <= 1'b0;
          state_q <= S_LO;
        end
        S_IDLE: if (accept) begin
          tx_q <= frame; nbits_q <= nbits; idx_q <= '0;
          det_q <= 1'b0;
          rd_q <= (mw_cmd_e'(cmd_i) == CMD_READ);
          wr_q <= (mw_cmd_e'(cmd_i) == CMD_WRITE);
          err_q <= 1'b0; tout_q <= 1'b0;
          state_q <= S_LO;
        end
        S_LO: if (tick) state_q <= S_HI;
        S_HI: if (tick) begin
          rx_q <= {rx_q[DATA_W-2:0], do_i};
          if (det_q && idx_q == DET_IDX) wide_q <= do_i;
          if (idx_q == nbits_q - 1'b1) begin
            state_q <= wr_q ? S_GAP : S_FIN;
          end else begin
            idx_q   <= idx_q + 1'b1;
            tx_q    <= tx_q << 1;
            state_q <= S_LO;
          end
        end
        S_GAP: if (tick) begin
          poll_q  <= '0;
          state_q <= S_POLL;
        end
        S_POLL: if (tick) begin
          if (do_i) state_q <= S_FIN;
          else if (poll_q == POLL_W'(POLL_MAX - 1)) begin
            tout_q  <= 1'b1;
            state_q <= S_FIN;
          end else poll_q <= poll_q + 1'b1;
        end
        S_FIN: if (tick) begin
          if (rd_q) rdata_q <= rx_q;
          err_q   <= tout_q;
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != S_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign rdata_o = rdata_q;
  assign addr8_o = wide_q;
  assign cs_o    = (state_q == S_LO) || (state_q == S_HI) || (state_q == S_POLL);
  assign sk_o    = (state_q == S_HI);
  assign di_o    = ((state_q == S_LO) || (state_q == S_HI)) && tx_q[FRAME_W-1];

  // checking state
  logic             sk_prev_q, det_seen_q;
  logic [DIV_W:0]   hold_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sk_prev_q <= 1'b0; hold_q <= '0; det_seen_q <= 1'b0;
    end else begin
      sk_prev_q  <= sk_o;
      det_seen_q <= det_seen_q || (state_q == S_IDLE);
      if (sk_o != sk_prev_q) hold_q <= '0;
      else if (!(&hold_q))   hold_q <= hold_q + 1'b1;
    end
  end

  assert_di_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_o |-> $stable(di_o));
  assert_half_period_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sk_o != sk_prev_q) |-> (hold_q >= {1'b0, half_div_i}));
  assert_cs_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (!cs_o && !$past(cs_o)));
  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_err_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o);
  assert_width_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_seen_q |-> $stable(addr8_o));
endmodule

// File: tb/tb_mw_eeprom_master.sv
module tb_mw_eeprom_master;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0, req = 1'b0;
  logic [1:0]  cmd = 2'd0;
  logic [7:0]  addr = 8'd0, half_div = 8'd1;
  logic [15:0] wdata = 16'd0;
  logic        busy, done, err, addr8, cs, sk, di, do_w;
  logic [15:0] rdata;

  mw_eeprom_master #(.DIV_W(8), .POLL_MAX(40)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .cmd_i(cmd), .addr_i(addr), .wdata_i(wdata),
    .half_div_i(half_div), .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata),
    .addr8_o(addr8), .cs_o(cs), .sk_o(sk), .di_o(di), .do_i(do_w)
  );

  // device model
  logic [15:0] mem [0:255];
  int model_aw = 8, model_busy_len = 30, busy_left = 0, nb = 0;
  logic m_do = 1'b1, started = 1'b0, ew = 1'b0, rd_ph = 1'b0, wr_pend = 1'b0, cs_p = 1'b0, sk_p = 1'b0;
  logic [31:0] sh = '0;
  logic [1:0]  opc = '0;
  logic [15:0] rdd = '0, wdat = '0;
  logic [7:0]  waddr = '0, ma;
  assign do_w = (busy_left != 0) ? 1'b0 : m_do;

  always @(negedge clk) begin
    if (busy_left > 0) begin
      busy_left = busy_left - 1;
      if (busy_left == 0) mem[waddr] = wdat;
    end
    if (cs_p && !cs) begin
      started = 1'b0; rd_ph = 1'b0; m_do = 1'b1;
      if (wr_pend) begin wr_pend = 1'b0; if (ew) busy_left = model_busy_len; end
    end else if (cs && sk && !sk_p) begin
      if (!started) begin
        if (di) begin started = 1'b1; nb = 0; sh = '0; end
      end else begin
        nb = nb + 1;
        sh = {sh[30:0], di};
        if (nb == 2) opc = sh[1:0];
        if (rd_ph) begin m_do = rdd[15]; rdd = rdd << 1; end
        if (nb == 2 + model_aw) begin
          ma = sh[7:0] & 8'((1 << model_aw) - 1);
          case (opc)
            2'b10: begin m_do = 1'b0; rdd = mem[ma]; rd_ph = 1'b1; end
            2'b00: begin
              if ((ma >> (model_aw - 2)) == 8'd3) ew = 1'b1;
              else if ((ma >> (model_aw - 2)) == 8'd0) ew = 1'b0;
            end
            2'b01: waddr = ma;
            default: ;
          endcase
        end
        if (opc == 2'b01 && nb == 2 + model_aw + 16) begin wdat = sh[15:0]; wr_pend = 1'b1; end
      end
    end
    cs_p = cs; sk_p = sk;
  end

  // pin monitor
  int pulses = 0, cs_rises = 0, hi_cnt = 0, last_hi = 0, di_bad = 0;
  logic mp_sk = 1'b0, mp_cs = 1'b0, mp_di = 1'b0;
  always @(negedge clk) begin
    if (sk && !mp_sk) pulses = pulses + 1;
    if (cs && !mp_cs) cs_rises = cs_rises + 1;
    if (sk && mp_sk && di != mp_di) di_bad = di_bad + 1;
    if (sk) hi_cnt = hi_cnt + 1;
    else if (mp_sk) begin last_hi = hi_cnt; hi_cnt = 0; end
    mp_sk = sk; mp_cs = cs; mp_di = di;
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic issue(input logic [1:0] c, input logic [7:0] a, input logic [15:0] d,
                       output int np, output int ncs, output logic e);
    int p0, c0;
    bit got;
    got = 0; p0 = pulses; c0 = cs_rises;
    @(negedge clk); req = 1'b1; cmd = c; addr = a; wdata = d;
    @(negedge clk); req = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      if (done) begin got = 1; break; end
      @(negedge clk);
    end
    e = err; np = pulses - p0; ncs = cs_rises - c0;
    chk(got, "R6", "done seen", longint'(got), 1);
    @(negedge clk);
    chk(done == 1'b0, "R6", "done lasts one cycle", longint'(done), 0);
  endtask

  task automatic do_reset(input int aw, input logic exp8);
    int p0;
    bit idle;
    model_aw = aw;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs == 0 && sk == 0 && di == 0, "R6", "pins low in reset", {cs, sk, di}, 0);
    chk(done == 0 && err == 0 && busy == 1, "R6", "flags in reset", {done, err, busy}, 1);
    p0 = pulses; idle = 0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1, "R1", "busy after reset", longint'(busy), 1);
    for (int k = 0; k < 2000; k++) begin
      if (!busy) begin idle = 1; break; end
      @(negedge clk);
    end
    chk(idle, "R1", "probe finished", longint'(idle), 1);
    chk(addr8 == exp8, "R1", "detected width", longint'(addr8), longint'(exp8));
    chk(pulses - p0 == 11, "R1", "probe pulses", pulses - p0, 11);
  endtask

  task automatic t_reads();
    int np, ncs; logic e;
    logic [7:0] list [4] = '{8'h00, 8'hA5, 8'hFF, 8'h3C};
    foreach (list[i]) begin
      issue(2'd0, list[i], 16'h0, np, ncs, e);
      chk(rdata == mem[list[i]], "R3", "read data", rdata, mem[list[i]]);
      chk(np == 27, "R3", "read pulses", np, 27);
    end
    chk(last_hi == 2, "R7", "high phase length div 1", last_hi, 2);
  endtask

  task automatic t_write_gate();
    int np, ncs; logic e; logic [15:0] old;
    old = mem[8'h12];
    issue(2'd3, 8'h12, 16'hBEEF, np, ncs, e);
    issue(2'd0, 8'h12, 16'h0, np, ncs, e);
    chk(rdata == old, "R4", "write without enable", rdata, old);
    issue(2'd1, 8'h00, 16'h0, np, ncs, e);
    chk(np == 11, "R4", "enable pulses", np, 11);
    issue(2'd3, 8'h12, 16'hBEEF, np, ncs, e);
    chk(np == 27, "R5", "write pulses", np, 27);
    chk(ncs == 2, "R5", "cs rises in write", ncs, 2);
    chk(e == 0, "R9", "no timeout on normal write", longint'(e), 0);
    issue(2'd0, 8'h12, 16'h0, np, ncs, e);
    chk(rdata == 16'hBEEF, "R5", "write readback", rdata, 16'hBEEF);
    issue(2'd2, 8'h00, 16'h0, np, ncs, e);
    chk(np == 11, "R4", "disable pulses", np, 11);
    issue(2'd3, 8'h12, 16'h1111, np, ncs, e);
    issue(2'd0, 8'h12, 16'h0, np, ncs, e);
    chk(rdata == 16'hBEEF, "R4", "write after disable", rdata, 16'hBEEF);
  endtask

  task automatic t_ignore_busy();
    int np, ncs, p0, rose; logic e; logic [15:0] keep;
    bit got;
    issue(2'd1, 8'h00, 16'h0, np, ncs, e);
    keep = mem[8'h33]; p0 = pulses; got = 0; rose = 0;
    @(negedge clk); req = 1'b1; cmd = 2'd0; addr = 8'h44;
    @(negedge clk); req = 1'b0;
    repeat (10) @(negedge clk);
    req = 1'b1; cmd = 2'd3; addr = 8'h33; wdata = 16'hDEAD;
    @(negedge clk); req = 1'b0;
    for (int k = 0; k < 2000; k++) begin
      if (done) begin got = 1; break; end
      @(negedge clk);
    end
    chk(got && rdata == mem[8'h44], "R8", "read unaffected by busy request", rdata, mem[8'h44]);
    chk(pulses - p0 == 27, "R8", "no extra frame", pulses - p0, 27);
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (busy) rose++;
    end
    chk(rose == 0, "R8", "stays idle after done", rose, 0);
    issue(2'd0, 8'h33, 16'h0, np, ncs, e);
    chk(rdata == keep, "R8", "ignored write left word", rdata, keep);
  endtask

  task automatic t_timeout();
    int np, ncs; logic e;
    issue(2'd1, 8'h00, 16'h0, np, ncs, e);
    model_busy_len = 2000;
    issue(2'd3, 8'h20, 16'h55AA, np, ncs, e);
    chk(e == 1, "R9", "error at done", longint'(e), 1);
    repeat (5) @(negedge clk);
    chk(err == 1, "R9", "error held", longint'(err), 1);
    while (busy_left != 0) @(negedge clk);
    model_busy_len = 30;
    @(negedge clk); req = 1'b1; cmd = 2'd0; addr = 8'h20;
    @(negedge clk); req = 1'b0;
    chk(err == 0, "R9", "error cleared on accept", longint'(err), 0);
    while (!done) @(negedge clk);
    chk(rdata == 16'h55AA, "R9", "late write landed", rdata, 16'h55AA);
    @(negedge clk);
  endtask

  task automatic t_divider();
    int np, ncs; logic e;
    half_div = 8'd3;
    issue(2'd0, 8'h07, 16'h0, np, ncs, e);
    chk(last_hi == 4, "R7", "high phase length div 3", last_hi, 4);
    chk(rdata == mem[8'h07], "R7", "read at slow rate", rdata, mem[8'h07]);
    half_div = 8'd0;
    issue(2'd0, 8'h08, 16'h0, np, ncs, e);
    chk(last_hi == 1, "R7", "high phase length div 0", last_hi, 1);
    chk(rdata == mem[8'h08], "R7", "read at fast rate", rdata, mem[8'h08]);
    half_div = 8'd1;
  endtask

  task automatic t_narrow();
    int np, ncs; logic e;
    do_reset(6, 1'b0);
    issue(2'd1, 8'h00, 16'h0, np, ncs, e);
    chk(np == 9, "R10", "enable pulses narrow", np, 9);
    issue(2'd3, 8'hC5, 16'hC0DE, np, ncs, e);
    chk(np == 25, "R10", "write pulses narrow", np, 25);
    issue(2'd0, 8'h05, 16'h0, np, ncs, e);
    chk(np == 25, "R3", "read pulses narrow", np, 25);
    chk(rdata == 16'hC0DE, "R10", "narrow readback", rdata, 16'hC0DE);
    issue(2'd0, 8'h2A, 16'h0, np, ncs, e);
    chk(rdata == mem[8'h2A], "R3", "narrow read", rdata, mem[8'h2A]);
    chk(addr8 == 0, "R10", "width held", longint'(addr8), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
    do_reset(8, 1'b1);
    t_reads();
    t_write_gate();
    t_ignore_busy();
    t_timeout();
    t_divider();
    chk(addr8 == 1, "R10", "wide width held", longint'(addr8), 1);
    t_narrow();
    chk(di_bad == 0, "R2", "di moves during high phase", di_bad, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end
endmodule